// File: doc/BRIEF.md
# Microprogram Sequencer with Field Decoder

This block is the control unit of a small microprogrammed processor. A micro-address register selects one of 32 microwords in a built-in control store. Each 28-bit microword is split into fields: ALU function, memory select with write enable, destination load, source drive, auxiliary control, and the address of the next microword. The load, drive and auxiliary codes are decoded into one-hot strobes for a bus-based datapath. That datapath (registers, ALU, memory) lies outside the block and sees only these strobes.

Every microword occupies one machine cycle of four phases, T1 to T4, each one clock long. Transfer strobes are active in T1 to T3. The micro-address register takes the next-address field at the end of T4. A start request in idle makes the block run continuously. A step request in idle runs exactly one machine cycle. A stop request takes effect only at a cycle boundary.

The control store holds a five-microword routine for a two-word ADD instruction. The routine moves PC to AR while incrementing PC, fetches the operand address into AR, loads the operand into DR2, copies R0 into DR1, and finally writes DR1 plus DR2 back to R0. It then loops to microword 0.

Top module: `useq_ctrl`

## Requirements
- R1: An active-low asynchronous reset forces idle: phase is 0, uaddr is 0, and every strobe and alu_fn are 0.
- R2: A start request sampled in idle begins T1 on the next clock. Phases then follow T1, T2, T3, T4 as phase bits 0, 1, 2, 3 (one-hot, one clock each). In run mode the phases repeat without gaps.
- R3: At the end of T4, uaddr loads the low 5 bits of the microword's next-address field (bits 5..0), and it holds during the rest of the cycle. The ADD routine visits 0, 1, 2, 3, 4 and then 0 again.
- R4: A step request sampled in idle runs exactly one four-phase cycle and then returns to idle. Start and step requests made while a cycle is in progress are ignored.
- R5: A stop request made during a cycle lets that cycle finish through T4 and then idles the block with uaddr already advanced. A stop request made in idle has no effect.
- R6: Strobes are active only in T1 to T3, never in T4 or idle. alu_fn shows the microword's S3..S0, M, Cn bits during all four phases and is 0 in idle.
- R7: The destination field (bits 14..12) decodes as follows: 110 gives ld_ar, 011 gives ld_dr2, 010 gives ld_dr1, 001 gives ld_gr. Any other code gives no load.
- R8: The source field (bits 11..9) decodes as follows: 000 drives nothing, 110 gives drv_pc, 001 gives drv_gr, 101 gives drv_alu.
- R9: Auxiliary code 110 (bits 8..6) gives pc_inc. A memory select of 01 (bits 16..15) gives mem_rd when WE (bit 17) is 0 and mem_wr when WE is 1. An all-zero microword gives no strobe.
- R10: The ADD routine has these per-microword strobes. Microword 0: ld_ar, drv_pc, pc_inc. Microword 1: ld_ar, mem_rd. Microword 2: ld_dr2, mem_rd. Microword 3: ld_dr1, drv_gr. Microword 4: ld_gr, drv_alu, with alu_fn 100101 (addition). alu_fn is 000000 in microwords 0 to 3, and mem_wr is never asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request continuous running |
| step | input | 1 | Request one machine cycle |
| stop | input | 1 | Request halt at the end of the current cycle |
| phase | output | 4 | One-hot phase, bit 0 = T1 through bit 3 = T4 |
| uaddr | output | 5 | Current micro-address |
| alu_fn | output | 6 | S3..S0, M, Cn of the current microword |
| ld_ar | output | 1 | Load address register |
| ld_dr1 | output | 1 | Load DR1 |
| ld_dr2 | output | 1 | Load DR2 |
| ld_gr | output | 1 | Load selected general register |
| drv_pc | output | 1 | Drive PC onto the bus |
| drv_gr | output | 1 | Drive selected general register onto the bus |
| drv_alu | output | 1 | Drive ALU result onto the bus |
| pc_inc | output | 1 | Increment PC |
| mem_rd | output | 1 | Memory read onto the bus |
| mem_wr | output | 1 | Memory write from the bus |

## Verification
On every cycle, the assertions check the following: the phase is one-hot, the order T1 to T4 holds, uaddr does not change in the middle of a cycle, no strobe is active in T4 or idle, and the load, drive and memory strobes never conflict. Only the bench scenarios can show the rest. These are the actual content of each ADD microword and the order in which the routine visits them. They also cover how start, step and stop interact (single-step halting, ignored mid-cycle requests, and stop taking effect at T2 versus T4) and the behaviour of an asynchronous reset in the middle of a cycle.

// File: rtl/useq_ctrl.sv
module useq_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       step,
  input  logic       stop,
  output logic [3:0] phase,
  output logic [4:0] uaddr,
  output logic [5:0] alu_fn,
  output logic       ld_ar,
  output logic       ld_dr1,
  output logic       ld_dr2,
  output logic       ld_gr,
  output logic       drv_pc,
  output logic       drv_gr,
  output logic       drv_alu,
  output logic       pc_inc,
  output logic       mem_rd,
  output logic       mem_wr
);
  localparam int UA_W = 5;
  localparam int MW_W = 28;

  function automatic logic [MW_W-1:0] cstore(input logic [UA_W-1:0] a);
    logic [MW_W-1:0] w;
    case (a)
      5'd0:    w = {4'h0, 6'b000000, 1'b0, 2'b00, 3'b110, 3'b110, 3'b110, 6'd1};
      5'd1:    w = {4'h0, 6'b000000, 1'b0, 2'b01, 3'b110, 3'b000, 3'b000, 6'd2};
      5'd2:    w = {4'h0, 6'b000000, 1'b0, 2'b01, 3'b011, 3'b000, 3'b000, 6'd3};
      5'd3:    w = {4'h0, 6'b000000, 1'b0, 2'b00, 3'b010, 3'b001, 3'b000, 6'd4};
      5'd4:    w = {4'h0, 6'b100101, 1'b0, 2'b00, 3'b001, 3'b101, 3'b000, 6'd0};
      default: w = '0;
    endcase
    return w;
  endfunction

  logic [MW_W-1:0] mw;
  logic [3:0]      rsvd_unused;
  logic            nxt_hi_unused;
  logic [5:0]      f_alu;
  logic            f_we;
  logic [1:0]      f_mem;
  logic [2:0]      f_a, f_b, f_c;
  logic [UA_W-1:0] f_nxt;

  logic            active, run_mode, stop_pend;
  logic [1:0]      ph;
  logic [UA_W-1:0] upc;

  assign mw            = cstore(upc);
  assign rsvd_unused   = mw[27:24];
  assign f_alu         = mw[23:18];
  assign f_we          = mw[17];
  assign f_mem         = mw[16:15];
  assign f_a           = mw[14:12];
  assign f_b           = mw[11:9];
  assign f_c           = mw[8:6];
  assign nxt_hi_unused = mw[5];
  assign f_nxt         = mw[4:0];

  wire last = active && (ph == 2'd3);
  wire halt = !run_mode || stop_pend || stop;
  wire xfer = active && (ph != 2'd3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      run_mode  <= 1'b0;
      stop_pend <= 1'b0;
      ph        <= 2'd0;
      upc       <= '0;
    end else if (!active) begin
      stop_pend <= 1'b0;
      ph        <= 2'd0;
      if (start) begin
        active   <= 1'b1;
        run_mode <= 1'b1;
      end else if (step) begin
        active   <= 1'b1;
        run_mode <= 1'b0;
      end
    end else begin
      ph <= ph + 2'd1;
      if (stop) stop_pend <= 1'b1;
      if (last) begin
        upc <= f_nxt;
        if (halt) begin
          active    <= 1'b0;
          stop_pend <= 1'b0;
        end
      end
    end
  end

  assign phase   = active ? (4'b0001 << ph) : 4'b0000;
  assign uaddr   = upc;
  assign alu_fn  = active ? f_alu : 6'b0;

  assign ld_ar   = xfer && (f_a == 3'b110);
  assign ld_dr2  = xfer && (f_a == 3'b011);
  assign ld_dr1  = xfer && (f_a == 3'b010);
  assign ld_gr   = xfer && (f_a == 3'b001);
  assign drv_pc  = xfer && (f_b == 3'b110);
  assign drv_gr  = xfer && (f_b == 3'b001);
  assign drv_alu = xfer && (f_b == 3'b101);
  assign pc_inc  = xfer && (f_c == 3'b110);
  assign mem_rd  = xfer && (f_mem == 2'b01) && !f_we;
  assign mem_wr  = xfer && (f_mem == 2'b01) && f_we;
endmodule

module useq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] phase,
  input logic [4:0] uaddr,
  input logic [5:0] alu_fn,
  input logic       ld_ar,
  input logic       ld_dr1,
  input logic       ld_dr2,
  input logic       ld_gr,
  input logic       drv_pc,
  input logic       drv_gr,
  input logic       drv_alu,
  input logic       pc_inc,
  input logic       mem_rd,
  input logic       mem_wr
);
  wire [9:0] strb = {ld_ar, ld_dr1, ld_dr2, ld_gr, drv_pc, drv_gr, drv_alu, pc_inc, mem_rd, mem_wr};

  p_phase_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(phase));
  p_t1_to_t2_r2: assert property (@(posedge clk) disable iff (!rst_n) phase == 4'b0001 |=> phase == 4'b0010);
  p_t2_to_t3_r2: assert property (@(posedge clk) disable iff (!rst_n) phase == 4'b0010 |=> phase == 4'b0100);
  p_t3_to_t4_r2: assert property (@(posedge clk) disable iff (!rst_n) phase == 4'b0100 |=> phase == 4'b1000);
  p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != 4'b0000 && !phase[3]) |=> $stable(uaddr));
  p_quiet_t4_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase[3] || phase == 4'b0000) |-> strb == 10'b0);
  p_alu_idle_r6: assert property (@(posedge clk) disable iff (!rst_n) phase == 4'b0000 |-> alu_fn == 6'b0);
  p_load_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({ld_ar, ld_dr1, ld_dr2, ld_gr}));
  p_drive_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({drv_pc, drv_gr, drv_alu}));
  p_mem_excl_r9: assert property (@(posedge clk) disable iff (!rst_n) !(mem_rd && mem_wr));
endmodule

bind useq_ctrl useq_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .phase(phase), .uaddr(uaddr), .alu_fn(alu_fn),
  .ld_ar(ld_ar), .ld_dr1(ld_dr1), .ld_dr2(ld_dr2), .ld_gr(ld_gr),
  .drv_pc(drv_pc), .drv_gr(drv_gr), .drv_alu(drv_alu), .pc_inc(pc_inc),
  .mem_rd(mem_rd), .mem_wr(mem_wr)
);

// File: tb/useq_ctrl_tb.sv
module useq_ctrl_tb_top;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, step = 1'b0, stop = 1'b0;
  logic [3:0] phase;
  logic [4:0] uaddr;
  logic [5:0] alu_fn;
  logic ld_ar, ld_dr1, ld_dr2, ld_gr, drv_pc, drv_gr, drv_alu, pc_inc, mem_rd, mem_wr;
  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  useq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .step(step), .stop(stop),
    .phase(phase), .uaddr(uaddr), .alu_fn(alu_fn),
    .ld_ar(ld_ar), .ld_dr1(ld_dr1), .ld_dr2(ld_dr2), .ld_gr(ld_gr),
    .drv_pc(drv_pc), .drv_gr(drv_gr), .drv_alu(drv_alu), .pc_inc(pc_inc),
    .mem_rd(mem_rd), .mem_wr(mem_wr)
  );

  wire [9:0] strb = {ld_ar, ld_dr1, ld_dr2, ld_gr, drv_pc, drv_gr, drv_alu, pc_inc, mem_rd, mem_wr};

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [9:0] exp_strb(input int a);
    case (a)
      0: return 10'b1000100100;
      1: return 10'b1000000010;
      2: return 10'b0010000010;
      3: return 10'b0100010000;
      4: return 10'b0001001000;
      default: return 10'b0;
    endcase
  endfunction

  task automatic check_idle(input int a, input string req);
    chk(phase == 4'b0, req, phase, 0);
    chk(uaddr == 5'(a), req, uaddr, a);
    chk(strb == 10'b0 && alu_fn == 6'b0, req, {strb, alu_fn}, 0);
  endtask

  // inj: 0 none, 1 start+step in T2, 2 stop in T2, 3 stop in T4
  task automatic run_cycle(input int a, input int inj);
    for (int p = 0; p < 4; p++) begin
      chk(phase == 4'(1 << p), "R2 phase order", phase, 1 << p);
      chk(uaddr == 5'(a), "R3 uaddr held", uaddr, a);
      chk(strb == ((p == 3) ? 10'b0 : exp_strb(a)), "R6/R7/R8/R9/R10 strobes", strb,
          (p == 3) ? 0 : exp_strb(a));
      chk(alu_fn == ((a == 4) ? 6'b100101 : 6'b0), "R10 alu_fn", alu_fn, (a == 4) ? 6'b100101 : 0);
      start = (inj == 1 && p == 1);
      step  = (inj == 1 && p == 1);
      stop  = (inj == 2 && p == 1) || (inj == 3 && p == 3);
      @(negedge clk);
    end
    start = 0; step = 0; stop = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #1;
    check_idle(0, "R1 reset state");
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_idle(0, "R1 idle after reset");

    stop = 1;
    @(negedge clk); @(negedge clk);
    stop = 0;
    check_idle(0, "R5 stop in idle ignored");
    @(negedge clk);
    check_idle(0, "R5 stop in idle ignored");

    step = 1; @(negedge clk); step = 0;
    run_cycle(0, 1);
    check_idle(1, "R4 single step halts");
    repeat (2) @(negedge clk);
    check_idle(1, "R4 mid-cycle start/step ignored");

    step = 1; @(negedge clk); step = 0;
    run_cycle(1, 0);
    check_idle(2, "R4 second step");

    start = 1; @(negedge clk);
    run_cycle(2, 0);
    run_cycle(3, 0);
    run_cycle(4, 0);
    run_cycle(0, 0);
    run_cycle(1, 0);
    run_cycle(2, 2);
    check_idle(3, "R5 stop in T2 halts after T4");
    repeat (3) @(negedge clk);
    check_idle(3, "R5 stays halted");

    start = 1; @(negedge clk);
    run_cycle(3, 0);
    run_cycle(4, 3);
    check_idle(0, "R5 stop in T4 halts, R3 wrap to 0");

    start = 1; @(negedge clk);
    run_cycle(0, 0);
    @(negedge clk);
    rst_n = 0; #1;
    check_idle(0, "R1 async reset mid-cycle");
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    check_idle(0, "R1 idle after second reset");

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule